// File: doc/BRIEF.md
# CPU Bus-Stuffing Store Sequencer

This block sits on the cartridge side of a 6502-family CPU bus. It feeds the CPU a small fixed set of instructions and follows each bus cycle of each one. On read cycles it drives opcode and operand bytes the way a ROM would. On write cycles it stops driving and instead produces per-bit pull-down enables, so that the all-ones value the CPU puts out becomes the value the cartridge wants. Commands come from an external queue through a valid/ready pair. A single store carries a zero-page address and one data byte. A double store carries two address/data pairs, and both pairs are forced onto the buses during the two write cycles of a zero-page read-modify-write.

Overrides only ever pull a line from 1 to 0. The read-modify-write opcode is chosen by a parameter: a rotate-left, or a decrement. With the decrement, the CPU puts 0xFE on the data bus in the final write cycle. Any request that would need a 0 line raised to 1 is refused for that cycle, and a sticky error flag is set. When the queue is empty, the block feeds 2-cycle NOPs, so the CPU keeps fetching without effect.

The caller must arrange the CPU state the block relies on: an accumulator of 0xFF for single stores, and memory byte 0x00FF equal to 0xFF with carry set for double stores.

Top module: `bstuff_seq`

## Requirements
- R1: While reset is held and in the first bus cycle after it, the block drives NOP opcode 0xEA with `data_oe` high, both pull-down outputs are zero and `force_err` is low.
- R2: With no command offered at an instruction boundary, the block emits a 2-cycle NOP and drives 0xEA with `data_oe` high on both of its cycles.
- R3: `cmd_ready` is high only while `cyc_en` is high in the final bus cycle of the current instruction. A command taken then starts with its opcode fetch in the next bus cycle, at cycle index 0.
- R4: A single store (`cmd_dbl`=0) runs 3 bus cycles. Cycle 0 drives 0x85. Cycle 1 drives `cmd_a0`. Cycle 2 is a write: `data_oe` is low, `data_pd` is the inverse of `cmd_d0`, and `addr_pd` is zero.
- R5: A double store (`cmd_dbl`=1) runs 5 bus cycles. Cycle 0 drives the opcode: 0x26 when RMW_DEC=0, 0xC6 when RMW_DEC=1. Cycle 1 drives 0xFF. Cycle 2 is undriven with no pull-downs. In cycle 3, `addr_pd`/`data_pd` are the inverses of `cmd_a0`/`cmd_d0`. In cycle 4 they are the inverses of `cmd_a1`/`cmd_d1`, with data bits limited to those the CPU drives high.
- R6: Pull-downs are nonzero only while `data_valid` is high during a write cycle, and never while `data_oe` is high.
- R7: With RMW_DEC=1, a double store whose `cmd_d1` bit 0 is 1 releases all pull-downs in cycle 4 and sets `force_err`. With RMW_DEC=0, no command sets `force_err`.
- R8: `force_err` stays high once set, until reset.
- R9: Back-to-back double stores take 5 bus cycles each, so six writes take 15 cycles. Back-to-back single stores take 3 cycles each, so six writes take 18 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several per bus cycle |
| rst_n | input | 1 | Active-low reset |
| cyc_en | input | 1 | High on the last clock of each bus cycle |
| data_valid | input | 1 | High during the data-valid phase of a bus cycle |
| cmd_valid | input | 1 | Queue holds a command |
| cmd_ready | output | 1 | Command taken at this clock |
| cmd_dbl | input | 1 | 1 = double store, 0 = single store |
| cmd_a0 | input | 8 | Single: zero-page address; double: first address low byte |
| cmd_d0 | input | 8 | First data byte |
| cmd_a1 | input | 8 | Second address low byte (double only) |
| cmd_d1 | input | 8 | Second data byte (double only) |
| data_out | output | 8 | Byte driven on read cycles |
| data_oe | output | 1 | Data bus drive enable |
| data_pd | output | 8 | Data line pull-down enables |
| addr_pd | output | 8 | Address low-byte pull-down enables |
| force_err | output | 1 | Sticky refused-override flag |

## Verification
Two functions share a cycle here. In the final write cycle of a decrement-variant double store, the refused-bit check, the pull-down suppression and the handshake for the next command all fall on the same clock. The bench sets this up by queueing double stores back to back, with and without bit 0 set in the second data byte. It runs a rotate instance and a decrement instance side by side on the same stimulus. For every cycle it checks that the decrement instance drops all its pull-downs and raises its error flag, while the rotate instance still applies the override and takes the next command without a lost cycle.

// File: rtl/bstuff_pkg.sv
package bstuff_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(5);

   localparam logic [BYTE_W-1:0] OPC_NOP  = 8'hEA;
   localparam logic [BYTE_W-1:0] OPC_STZ  = 8'h85;
   localparam logic [BYTE_W-1:0] OPC_ROLZ = 8'h26;
   localparam logic [BYTE_W-1:0] OPC_DECZ = 8'hC6;
   localparam logic [BYTE_W-1:0] ZP_TOP   = 8'hFF;

   typedef enum logic [1:0] {
      INS_NOP = 2'd0,
      INS_ST1 = 2'd1,
      INS_RMW = 2'd2
   } ins_e;

   function automatic logic [CNT_W-1:0] ins_last(input ins_e k);
      case (k)
         INS_ST1: return CNT_W'(2);
         INS_RMW: return CNT_W'(4);
         default: return CNT_W'(1);
      endcase
   endfunction
endpackage

// File: rtl/bstuff_ctrl.sv
module bstuff_ctrl
   import bstuff_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              cmd_valid,
   input  logic              cmd_dbl,
   input  logic [DATA_W-1:0] cmd_a0,
   input  logic [DATA_W-1:0] cmd_d0,
   input  logic [DATA_W-1:0] cmd_a1,
   input  logic [DATA_W-1:0] cmd_d1,
   output logic              cmd_ready,
   output ins_e              ins,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] h_a0,
   output logic [DATA_W-1:0] h_d0,
   output logic [DATA_W-1:0] h_a1,
   output logic [DATA_W-1:0] h_d1
);
   logic at_last;

   assign at_last   = (cnt == ins_last(ins));
   assign cmd_ready = cyc_en & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins  <= INS_NOP;
         cnt  <= '0;
         h_a0 <= '0;
         h_d0 <= '0;
         h_a1 <= '0;
         h_d1 <= '0;
      end else if (cyc_en) begin
         if (at_last) begin
            cnt <= '0;
            if (cmd_valid) begin
               ins  <= cmd_dbl ? INS_RMW : INS_ST1;
               h_a0 <= cmd_a0;
               h_d0 <= cmd_d0;
               h_a1 <= cmd_a1;
               h_d1 <= cmd_d1;
            end else begin
               ins <= INS_NOP;
            end
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // R3: an instruction that is not finished keeps its kind
   assert_hold_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !at_last) |=> (ins == $past(ins)));
endmodule

// File: rtl/bstuff_drive.sv
module bstuff_drive
   import bstuff_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit RMW_DEC = 1'b0
) (
   input  ins_e              ins,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] h_a0,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              wr_cyc,
   output logic              wr_slot
);
   localparam logic [DATA_W-1:0] RMW_OPC = RMW_DEC ? OPC_DECZ : OPC_ROLZ;

   always_comb begin
      data_out = '0;
      data_oe  = 1'b0;
      wr_cyc   = 1'b0;
      wr_slot  = 1'b0;
      case (ins)
         INS_ST1: begin
            case (cnt)
               CNT_W'(0): begin data_out = OPC_STZ; data_oe = 1'b1; end
               CNT_W'(1): begin data_out = h_a0;    data_oe = 1'b1; end
               default:   wr_cyc = 1'b1;
            endcase
         end
         INS_RMW: begin
            case (cnt)
               CNT_W'(0): begin data_out = RMW_OPC; data_oe = 1'b1; end
               CNT_W'(1): begin data_out = ZP_TOP;  data_oe = 1'b1; end
               CNT_W'(2): ;
               CNT_W'(3): wr_cyc = 1'b1;
               default: begin wr_cyc = 1'b1; wr_slot = 1'b1; end
            endcase
         end
         default: begin
            data_out = OPC_NOP;
            data_oe  = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/bstuff_mask.sv
module bstuff_mask
   import bstuff_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit RMW_DEC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              data_valid,
   input  logic              wr_cyc,
   input  logic              wr_slot,
   input  logic              addr_ovr,
   input  logic [DATA_W-1:0] req_a0,
   input  logic [DATA_W-1:0] req_d0,
   input  logic [DATA_W-1:0] req_a1,
   input  logic [DATA_W-1:0] req_d1,
   output logic [DATA_W-1:0] addr_pd,
   output logic [DATA_W-1:0] data_pd,
   output logic              err
);
   logic [DATA_W-1:0] cpu_last, cpu_d, req_d, req_a;
   logic              force1, apply;

   generate
      if (RMW_DEC) begin : g_dec
         assign cpu_last = {{(DATA_W-1){1'b1}}, 1'b0};
      end else begin : g_rol
         assign cpu_last = '1;
      end
   endgenerate

   assign cpu_d  = wr_slot ? cpu_last : '1;
   assign req_d  = wr_slot ? req_d1 : req_d0;
   assign req_a  = wr_slot ? req_a1 : req_a0;
   assign force1 = wr_cyc & (|(req_d & ~cpu_d));
   assign apply  = wr_cyc & data_valid & ~force1;

   assign data_pd = apply ? (~req_d & cpu_d) : '0;
   assign addr_pd = (apply & addr_ovr) ? ~req_a : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                err <= 1'b0;
      else if (cyc_en && force1) err <= 1'b1;
   end

   // R8: the refused-override flag never clears on its own
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R6: no line is pulled outside the data-valid phase
   assert_pd_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> (data_pd == '0 && addr_pd == '0));
endmodule

// File: rtl/bstuff_seq.sv
module bstuff_seq
   import bstuff_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit RMW_DEC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              data_valid,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_dbl,
   input  logic [DATA_W-1:0] cmd_a0,
   input  logic [DATA_W-1:0] cmd_d0,
   input  logic [DATA_W-1:0] cmd_a1,
   input  logic [DATA_W-1:0] cmd_d1,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic [DATA_W-1:0] data_pd,
   output logic [DATA_W-1:0] addr_pd,
   output logic              force_err
);
   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("bstuff_seq: DATA_W must equal the CPU byte width");
      end
   endgenerate

   ins_e              ins;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] h_a0, h_d0, h_a1, h_d1;
   logic              wr_cyc, wr_slot;

   bstuff_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
      .cmd_valid(cmd_valid), .cmd_dbl(cmd_dbl),
      .cmd_a0(cmd_a0), .cmd_d0(cmd_d0), .cmd_a1(cmd_a1), .cmd_d1(cmd_d1),
      .cmd_ready(cmd_ready), .ins(ins), .cnt(cnt),
      .h_a0(h_a0), .h_d0(h_d0), .h_a1(h_a1), .h_d1(h_d1)
   );

   bstuff_drive #(.DATA_W(DATA_W), .RMW_DEC(RMW_DEC)) u_drive (
      .ins(ins), .cnt(cnt), .h_a0(h_a0),
      .data_out(data_out), .data_oe(data_oe),
      .wr_cyc(wr_cyc), .wr_slot(wr_slot)
   );

   bstuff_mask #(.DATA_W(DATA_W), .RMW_DEC(RMW_DEC)) u_mask (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .data_valid(data_valid),
      .wr_cyc(wr_cyc), .wr_slot(wr_slot), .addr_ovr(ins == INS_RMW),
      .req_a0(h_a0), .req_d0(h_d0), .req_a1(h_a1), .req_d1(h_d1),
      .addr_pd(addr_pd), .data_pd(data_pd), .err(force_err)
   );

   // R6: driving a byte and pulling lines never overlap
   assert_drive_vs_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (data_pd == '0 && addr_pd == '0));
   // R3: a taken command begins with its opcode fetch
   assert_accept_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (data_oe &&
         (data_out == OPC_STZ || data_out == OPC_ROLZ || data_out == OPC_DECZ)));
endmodule

// File: tb/bstuff_seq_test.sv
module bstuff_seq_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, cyc_en, dv, cv, cdbl;
   logic [7:0] ca0, cd0, ca1, cd1;
   logic       rdy_r, oe_r, err_r, rdy_d, oe_d, err_d;
   logic [7:0] out_r, dpd_r, apd_r, out_d, dpd_d, apd_d;

   bstuff_seq #(.DATA_W(8), .RMW_DEC(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .data_valid(dv),
      .cmd_valid(cv), .cmd_ready(rdy_r), .cmd_dbl(cdbl),
      .cmd_a0(ca0), .cmd_d0(cd0), .cmd_a1(ca1), .cmd_d1(cd1),
      .data_out(out_r), .data_oe(oe_r), .data_pd(dpd_r), .addr_pd(apd_r),
      .force_err(err_r));

   bstuff_seq #(.DATA_W(8), .RMW_DEC(1'b1)) uut_dec (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .data_valid(dv),
      .cmd_valid(cv), .cmd_ready(rdy_d), .cmd_dbl(cdbl),
      .cmd_a0(ca0), .cmd_d0(cd0), .cmd_a1(ca1), .cmd_d1(cd1),
      .data_out(out_d), .data_oe(oe_d), .data_pd(dpd_d), .addr_pd(apd_d),
      .force_err(err_d));

   int checks = 0, fails = 0;
   bit       q_dbl [0:1023];
   logic [7:0] q_a0 [0:1023], q_d0 [0:1023], q_a1 [0:1023], q_d1 [0:1023];
   int qh = 0, qt = 0;
   int m_k = 0, m_c = 0, busy = 0;
   logic [7:0] m_a0 = 0, m_d0 = 0, m_a1 = 0, m_d1 = 0;
   bit m_err = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int last_of(input int k);
      return (k == 0) ? 1 : ((k == 1) ? 2 : 4);
   endfunction

   function automatic string tag_of(input int k);
      return (k == 0) ? "R2" : ((k == 1) ? "R4" : "R5");
   endfunction

   // expected read-cycle drive and write-phase pull-downs for the current model state
   task automatic expect_at(input bit dec, output bit oe, output logic [7:0] out,
                            output logic [7:0] apd, output logic [7:0] dpd, output bit ferr);
      logic [7:0] cpu;
      oe = 1'b0; out = 8'h00; apd = 8'h00; dpd = 8'h00; ferr = 1'b0;
      if (m_k == 0) begin
         oe = 1'b1; out = 8'hEA;
      end else if (m_k == 1) begin
         if (m_c == 0) begin oe = 1'b1; out = 8'h85; end
         else if (m_c == 1) begin oe = 1'b1; out = m_a0; end
         else dpd = ~m_d0;
      end else begin
         if (m_c == 0) begin oe = 1'b1; out = dec ? 8'hC6 : 8'h26; end
         else if (m_c == 1) begin oe = 1'b1; out = 8'hFF; end
         else if (m_c == 3) begin apd = ~m_a0; dpd = ~m_d0; end
         else if (m_c == 4) begin
            cpu = dec ? 8'hFE : 8'hFF;
            if ((m_d1 & ~cpu) != 0) ferr = 1'b1;
            else begin apd = ~m_a1; dpd = ~m_d1 & cpu; end
         end
      end
   endtask

   task automatic push(input bit dbl, input logic [7:0] a0, input logic [7:0] d0,
                       input logic [7:0] a1, input logic [7:0] d1);
      q_dbl[qt] = dbl; q_a0[qt] = a0; q_d0[qt] = d0; q_a1[qt] = a1; q_d1[qt] = d1;
      qt++;
   endtask

   task automatic bus_cycle();
      bit eo, ef, eo2, ef2;
      logic [7:0] eout, eapd, edpd, eout2, eapd2, edpd2;
      string tg;
      tg = tag_of(m_k);
      expect_at(1'b0, eo, eout, eapd, edpd, ef);
      expect_at(1'b1, eo2, eout2, eapd2, edpd2, ef2);
      @(negedge clk);
      dv = 1'b0; cyc_en = 1'b0;
      cv = (qh < qt);
      if (qh < qt) begin
         cdbl = q_dbl[qh]; ca0 = q_a0[qh]; cd0 = q_d0[qh]; ca1 = q_a1[qh]; cd1 = q_d1[qh];
      end
      #1;
      chk(oe_r == eo, {tg, " oe"}, oe_r, eo);
      if (eo) chk(out_r == eout, {tg, " byte"}, out_r, eout);
      chk(oe_d == eo2, {tg, " oe dec"}, oe_d, eo2);
      if (eo2) chk(out_d == eout2, {tg, " byte dec"}, out_d, eout2);
      chk({dpd_r, apd_r, dpd_d, apd_d} == 32'h0, "R6 pull outside phase",
          {dpd_r, apd_r, dpd_d, apd_d}, 0);
      chk(err_r == 1'b0, "R7 rotate err", err_r, 0);
      chk(err_d == m_err, "R8 dec err", err_d, m_err);
      if (!(oe_r && out_r == 8'hEA)) busy++;
      @(negedge clk);
      @(negedge clk);
      dv = 1'b1;
      #1;
      chk(dpd_r == edpd && apd_r == eapd, {tg, " pull"}, {apd_r, dpd_r}, {eapd, edpd});
      chk(dpd_d == edpd2 && apd_d == eapd2, ef2 ? "R7 pull dec" : {tg, " pull dec"},
          {apd_d, dpd_d}, {eapd2, edpd2});
      @(negedge clk);
      cyc_en = 1'b1;
      #1;
      chk(rdy_r == (m_c == last_of(m_k)), "R3 ready", rdy_r, (m_c == last_of(m_k)));
      chk(rdy_d == rdy_r, "R3 ready dec", rdy_d, rdy_r);
      if (ef2) m_err = 1'b1;
      if (m_c == last_of(m_k)) begin
         m_c = 0;
         if (cv) begin
            m_k = q_dbl[qh] ? 2 : 1;
            m_a0 = q_a0[qh]; m_d0 = q_d0[qh]; m_a1 = q_a1[qh]; m_d1 = q_d1[qh];
            qh++;
         end else m_k = 0;
      end else m_c++;
   endtask

   task automatic drain();
      while (qh < qt || m_k != 0) bus_cycle();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; dv = 1'b0; cyc_en = 1'b0; cv = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(oe_r && out_r == 8'hEA, "R1 reset byte", out_r, 8'hEA);
      chk({dpd_r, apd_r, dpd_d, apd_d} == 32'h0, "R1 reset pull",
          {dpd_r, apd_r, dpd_d, apd_d}, 0);
      chk(err_r == 1'b0 && err_d == 1'b0, "R1 R8 reset err", {err_r, err_d}, 0);
      rst_n = 1'b1;
      m_k = 0; m_c = 0; m_err = 1'b0; qh = qt;
   endtask

   initial begin
      #(8 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; cyc_en = 1'b0; dv = 1'b0; cv = 1'b0; cdbl = 1'b0;
      ca0 = 0; cd0 = 0; ca1 = 0; cd1 = 0;
      do_reset();
      // R1/R2: idle run of NOPs
      repeat (6) bus_cycle();
      // R4: single store
      push(1'b0, 8'h10, 8'h5A, 8'h00, 8'h00);
      drain();
      repeat (2) bus_cycle();
      // R9: three double stores back to back = 15 cycles
      busy = 0;
      for (int i = 0; i < 3; i++) push(1'b1, 8'h30 + i, 8'h0F << i, 8'h40 + i, 8'hA4 + i * 2);
      drain();
      repeat (2) bus_cycle();
      chk(busy == 15, "R9 double burst", busy, 15);
      // R9: six single stores = 18 cycles
      busy = 0;
      for (int i = 0; i < 6; i++) push(1'b0, 8'h20 + i, 8'h11 * i, 8'h00, 8'h00);
      drain();
      repeat (2) bus_cycle();
      chk(busy == 18, "R9 single burst", busy, 18);
      // R7: decrement cannot raise bit 0 of the second byte, next command follows at once
      push(1'b1, 8'h06, 8'h3C, 8'h07, 8'h81);
      push(1'b1, 8'h08, 8'hF0, 8'h09, 8'h80);
      drain();
      repeat (2) bus_cycle();
      chk(err_d == 1'b1 && err_r == 1'b0, "R7 flag split", {err_d, err_r}, 2'b10);
      // constrained random traffic with gaps
      for (int n = 0; n < 300; n++) begin
         push($urandom_range(0, 1), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
         if ($urandom_range(0, 3) == 0) begin
            drain();
            repeat ($urandom_range(1, 3)) bus_cycle();
         end
      end
      drain();
      repeat (2) bus_cycle();
      // R8: flag clears only on reset
      do_reset();
      repeat (3) bus_cycle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule